// File: doc/BRIEF.md
# Video Fetch Bus Cycle Driver

This block takes over the system bus for the video subsystem while a display-memory fetch cycle is active. It places a programmed upper-address slice and a pair of active-low memory chip-select lines on the bus. It drives the lowest address line and the active-low high-byte enable low, so every fetch is a full 16-bit word. It also produces the active-low memory read strobe.

The read strobe takes its timing from two inputs. One is the character clock. The other is a copy of that clock delayed by roughly 100 ns. Both arrive as synchronous inputs sampled on the system clock. When the block sees a character clock rising edge, it arms. On the first delayed-clock rising edge after that, it pulls the strobe low. The strobe stays low until the next character clock rising edge.

Software sets the upper address and the chip selects through a small register with a write strobe. The arbitration that raises the cycle flag and the data path are handled elsewhere.

Top module: `vdma_bus_driver`

## Requirements
- R1: When reset is released, every enable output is 0, `bus_mrd_n` is 1, `bus_bhe_n` is 1, `bus_mcs_n` is all ones and `bus_addr_hi` is 0. The setting register holds zero, so a fetch cycle that starts before any write drives an address of 0 and chip selects of 0.
- R2: When `cfg_we` is high at a clock edge, that edge loads `cfg_wdata`. Bits [AW-1:0] are the upper-address slice, with bit 0 going to the lowest line of the slice. Bits [AW+CW-1:AW] are the chip-select values, with bit AW going to `bus_mcs_n[0]`. The register keeps its value while `cfg_we` is low.
- R3: One clock edge after `vcycle` is sampled high, `bus_addr_oe` is 1 and `bus_addr_hi` and `bus_mcs_n` show the register fields.
- R4: One clock edge after `vcycle` is sampled high, `bus_lo_oe` is 1, `bus_a0` is 0 and `bus_bhe_n` is 0.
- R5: One clock edge after `vcycle` is sampled low, all enables are 0, `bus_addr_hi` is 0, `bus_mcs_n` is all ones, `bus_bhe_n` is 1 and `bus_mrd_n` is 1.
- R6: During a cycle, a rising edge of `cclk` (a sample of 1 following a sample of 0) arms the strobe without lowering it. The first `dclk` rising edge sampled after that drives `bus_mrd_n` to 0 one edge later. `bus_mrd_oe` follows `bus_addr_oe`.
- R7: Once low, `bus_mrd_n` stays 0 through later `dclk` edges and through `cclk` falling. It returns to 1 one edge after the next `cclk` rising edge is sampled.
- R8: A `dclk` rising edge that arrives without a `cclk` rising edge since the last strobe has no effect: `bus_mrd_n` stays 1.
- R9: If `cclk` and `dclk` both rise in the same sample, the block only arms. The strobe falls on a later `dclk` rise.
- R10: Dropping `vcycle` ends the strobe and clears the armed state. After a new cycle starts, a `dclk` rise with no fresh `cclk` rise leaves `bus_mrd_n` at 1.
- R11: A register write made while a cycle is active shows on `bus_addr_hi` and `bus_mcs_n` two edges after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting register write strobe |
| cfg_wdata | input | AW+CW | Setting register write data |
| vcycle | input | 1 | Video fetch cycle active |
| cclk | input | 1 | Sampled character clock |
| dclk | input | 1 | Sampled delayed character clock |
| bus_addr_hi | output | AW | Upper address slice value |
| bus_addr_oe | output | 1 | Drive enable for upper address and chip selects |
| bus_mcs_n | output | CW | Memory chip-select values, active low |
| bus_a0 | output | 1 | Lowest address line value |
| bus_bhe_n | output | 1 | High-byte enable value, active low |
| bus_lo_oe | output | 1 | Drive enable for lowest address line and byte enable |
| bus_mrd_n | output | 1 | Memory read strobe, active low |
| bus_mrd_oe | output | 1 | Drive enable for the read strobe |

## Verification
The bench builds the block with the default five-bit address slice and two chip selects. This lets it drive alternating and all-ones patterns into both fields and confirm that no bit of one field leaks into the other. With these small widths, every bit position is visible in a single comparison. The strobe scenarios step `cclk` and `dclk` one sample at a time. That reaches the arm-only case, the simultaneous-rise case, the strobe with no arm, and a cycle that ends in the middle of a strobe.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef struct packed {
        logic cclk;
        logic dclk;
        logic armed;
        logic low;
    } strb_s;
endpackage

// File: rtl/vdma_cfg_reg.sv
module vdma_cfg_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) val_d = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (val == $past(wdata)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(val));
endmodule

// File: rtl/vdma_strobe_gen.sv
module vdma_strobe_gen
    import vdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vcycle,
    input  logic cclk,
    input  logic dclk,
    output logic strobe_low
);
    strb_s st_d, st_q;
    logic  cclk_rise, dclk_rise;

    assign cclk_rise = cclk & ~st_q.cclk;
    assign dclk_rise = dclk & ~st_q.dclk;

    always_comb begin
        st_d      = st_q;
        st_d.cclk = cclk;
        st_d.dclk = dclk;
        if (!vcycle) begin
            st_d.armed = 1'b0;
            st_d.low   = 1'b0;
        end else if (cclk_rise) begin
            st_d.armed = 1'b1;
            st_d.low   = 1'b0;
        end else if (st_q.armed && dclk_rise) begin
            st_d.armed = 1'b0;
            st_d.low   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe_low = st_q.low;

    p_fall_on_dclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.low) |-> $past(dclk_rise && vcycle));
    p_end_on_cclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.low) |-> $past(cclk_rise || !vcycle));
    p_not_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.low && st_q.armed));
endmodule

// File: rtl/vdma_bus_drive.sv
module vdma_bus_drive #(
    parameter int AW = 5,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcycle,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_cs,
    output logic          drive,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cs_n
);
    typedef struct packed {
        logic          drive;
        logic [AW-1:0] addr;
        logic [CW-1:0] cs_n;
    } drv_s;

    drv_s          dv_d, dv_q;
    logic [AW-1:0] addr_gated;
    logic [CW-1:0] cs_gated;

    for (genvar i = 0; i < AW; i++) begin : g_addr
        assign addr_gated[i] = vcycle & cfg_addr[i];
    end
    for (genvar j = 0; j < CW; j++) begin : g_cs
        assign cs_gated[j] = ~vcycle | cfg_cs[j];
    end

    always_comb begin
        dv_d       = dv_q;
        dv_d.drive = vcycle;
        dv_d.addr  = addr_gated;
        dv_d.cs_n  = cs_gated;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q.drive <= 1'b0;
            dv_q.addr  <= '0;
            dv_q.cs_n  <= '1;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign drive = dv_q.drive;
    assign addr  = dv_q.addr;
    assign cs_n  = dv_q.cs_n;

    p_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vcycle |=> (addr == $past(cfg_addr)) && (cs_n == $past(cfg_cs)));
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vcycle |=> (addr == '0) && (cs_n == '1));
endmodule

// File: rtl/vdma_bus_driver.sv
module vdma_bus_driver #(
    parameter int AW = 5,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW+CW-1:0] cfg_wdata,
    input  logic             vcycle,
    input  logic             cclk,
    input  logic             dclk,
    output logic [AW-1:0]    bus_addr_hi,
    output logic             bus_addr_oe,
    output logic [CW-1:0]    bus_mcs_n,
    output logic             bus_a0,
    output logic             bus_bhe_n,
    output logic             bus_lo_oe,
    output logic             bus_mrd_n,
    output logic             bus_mrd_oe
);
    localparam int CFG_W = AW + CW;

    logic [CFG_W-1:0] cfg_val;
    logic             drive;
    logic             strobe_low;

    vdma_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .val   (cfg_val)
    );

    vdma_strobe_gen u_strb (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcycle     (vcycle),
        .cclk       (cclk),
        .dclk       (dclk),
        .strobe_low (strobe_low)
    );

    vdma_bus_drive #(.AW(AW), .CW(CW)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .vcycle   (vcycle),
        .cfg_addr (cfg_val[AW-1:0]),
        .cfg_cs   (cfg_val[CFG_W-1:AW]),
        .drive    (drive),
        .addr     (bus_addr_hi),
        .cs_n     (bus_mcs_n)
    );

    assign bus_addr_oe = drive;
    assign bus_lo_oe   = drive;
    assign bus_mrd_oe  = drive;
    assign bus_a0      = 1'b0;
    assign bus_bhe_n   = ~drive;
    assign bus_mrd_n   = ~(drive & strobe_low);

    p_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vcycle |=> bus_lo_oe && !bus_bhe_n && !bus_a0);
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vcycle |=> !bus_addr_oe && !bus_lo_oe && !bus_mrd_oe && bus_mrd_n);
    p_strobe_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mrd_n |-> bus_mrd_oe);
endmodule

// File: tb/tb_vdma_bus_driver.sv
module tb_vdma_bus_driver;
    localparam int AW = 5;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW+CW-1:0] cfg_wdata = '0;
    logic          vcycle = 1'b0;
    logic          cclk = 1'b0;
    logic          dclk = 1'b0;
    logic [AW-1:0] bus_addr_hi;
    logic          bus_addr_oe;
    logic [CW-1:0] bus_mcs_n;
    logic          bus_a0, bus_bhe_n, bus_lo_oe, bus_mrd_n, bus_mrd_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vdma_bus_driver #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .vcycle(vcycle), .cclk(cclk), .dclk(dclk),
        .bus_addr_hi(bus_addr_hi), .bus_addr_oe(bus_addr_oe),
        .bus_mcs_n(bus_mcs_n), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
        .bus_lo_oe(bus_lo_oe), .bus_mrd_n(bus_mrd_n), .bus_mrd_oe(bus_mrd_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] c);
        cfg_we = 1'b1;
        cfg_wdata = {c, a};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " addr_oe"}, bus_addr_oe, 0);
        chk({tag, " lo_oe"}, bus_lo_oe, 0);
        chk({tag, " mrd_oe"}, bus_mrd_oe, 0);
        chk({tag, " mrd_n"}, bus_mrd_n, 1);
        chk({tag, " bhe_n"}, bus_bhe_n, 1);
        chk({tag, " mcs_n"}, bus_mcs_n, 2'b11);
        chk({tag, " addr"}, bus_addr_hi, 0);
    endtask

    task automatic t_reset_r1();
        chk_idle("R1 reset");
        vcycle = 1'b1;
        tick();
        chk("R1 zero addr", bus_addr_hi, 0);
        chk("R1 zero cs", bus_mcs_n, 0);
        vcycle = 1'b0;
        tick();
    endtask

    task automatic t_fields_r2_r3_r4();
        wr(5'b10101, 2'b01);
        vcycle = 1'b1;
        tick();
        chk("R3 addr_oe", bus_addr_oe, 1);
        chk("R2 R3 addr", bus_addr_hi, 5'b10101);
        chk("R2 R3 cs", bus_mcs_n, 2'b01);
        chk("R4 lo_oe", bus_lo_oe, 1);
        chk("R4 a0", bus_a0, 0);
        chk("R4 bhe_n", bus_bhe_n, 0);
        chk("R6 mrd_oe", bus_mrd_oe, 1);
        vcycle = 1'b0;
        tick();
        chk_idle("R5 release");
        wr(5'b11111, 2'b10);
        tick();
        vcycle = 1'b1;
        tick();
        chk("R2 hold addr", bus_addr_hi, 5'b11111);
        chk("R2 hold cs", bus_mcs_n, 2'b10);
        vcycle = 1'b0;
        tick();
    endtask

    task automatic t_write_in_cycle_r11();
        vcycle = 1'b1;
        tick();
        cfg_we = 1'b1;
        cfg_wdata = {2'b00, 5'b01010};
        tick();
        cfg_we = 1'b0;
        chk("R11 old after 1", bus_addr_hi, 5'b11111);
        tick();
        chk("R11 new addr", bus_addr_hi, 5'b01010);
        chk("R11 new cs", bus_mcs_n, 2'b00);
        vcycle = 1'b0;
        tick();
    endtask

    task automatic t_strobe_r6_r7_r8();
        cclk = 1'b0; dclk = 1'b0; vcycle = 1'b1;
        tick();
        dclk = 1'b1; tick();
        chk("R8 no arm", bus_mrd_n, 1);
        dclk = 1'b0; tick();
        cclk = 1'b1; tick();
        chk("R6 arm only", bus_mrd_n, 1);
        tick();
        dclk = 1'b1; tick();
        chk("R6 strobe low", bus_mrd_n, 0);
        chk("R6 strobe oe", bus_mrd_oe, 1);
        cclk = 1'b0; tick();
        chk("R7 hold cclk fall", bus_mrd_n, 0);
        dclk = 1'b0; tick();
        dclk = 1'b1; tick();
        chk("R7 hold dclk", bus_mrd_n, 0);
        cclk = 1'b1; tick();
        chk("R7 end", bus_mrd_n, 1);
        dclk = 1'b0; tick();
        dclk = 1'b1; tick();
        chk("R6 second strobe", bus_mrd_n, 0);
        cclk = 1'b0; dclk = 1'b0; vcycle = 1'b0;
        tick();
    endtask

    task automatic t_same_r9();
        vcycle = 1'b1; tick();
        cclk = 1'b1; dclk = 1'b1; tick();
        chk("R9 arm only", bus_mrd_n, 1);
        dclk = 1'b0; tick();
        dclk = 1'b1; tick();
        chk("R9 later low", bus_mrd_n, 0);
        cclk = 1'b0; dclk = 1'b0; vcycle = 1'b0;
        tick();
    endtask

    task automatic t_drop_r10();
        vcycle = 1'b1; tick();
        cclk = 1'b1; tick();
        dclk = 1'b1; tick();
        chk("R10 low", bus_mrd_n, 0);
        vcycle = 1'b0; tick();
        chk("R10 end", bus_mrd_n, 1);
        chk("R10 oe off", bus_mrd_oe, 0);
        cclk = 1'b0; dclk = 1'b0; tick();
        vcycle = 1'b1; tick();
        cclk = 1'b1; dclk = 1'b0; vcycle = 1'b0; tick();
        vcycle = 1'b1; tick();
        dclk = 1'b1; tick();
        chk("R10 cleared arm", bus_mrd_n, 1);
        vcycle = 1'b0; cclk = 1'b0; dclk = 1'b0; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_fields_r2_r3_r4();
        t_write_in_cycle_r11();
        t_strobe_r6_r7_r8();
        t_same_r9();
        t_drop_r10();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule